// File: doc/BRIEF.md
# Light-Load Burst Supervisor

This block decides when a quasi-resonant flyback controller drops into a burst regime at light load, runs the switching pulses while it is there, and hands control back to normal valley switching when the load returns. It sees the feedback node only through four comparator flags: entry level, burst-on level, burst-off level and exit level. It also takes the present valley-count setting and a current-sense flag that trips at the reduced burst peak limit. The analog thresholds, the comparators and the gate driver sit outside the block.

Entering burst requires low feedback and the valley count at its maximum (7), both held over a long blanking window. If either one drops during the window, the window starts again. Inside the burst, the feedback moves up and down between the on and off levels. That hysteresis band switches a fixed-frequency pulse generator on and off. Each pulse is capped at half the period and is cut early by the current-sense flag. When the feedback passes the exit level, the block leaves burst and sends a one-cycle pulse that forces the external valley counter back to 1.

The state machine has five states:
- `ST_NORMAL`: normal switching.
- `ST_BLANK`: the entry window is being timed.
- `ST_BIDLE`: in burst, with switching paused.
- `ST_BRUN`: in burst, with pulses running.
- `ST_EXIT`: a one-cycle state that issues the valley reset.

The transitions are:
- NORMAL→BLANK when the entry conditions are present.
- BLANK→NORMAL when either condition is lost.
- BLANK→BIDLE when the window completes.
- BIDLE→BRUN on the burst-on flag.
- BRUN→BIDLE on the burst-off flag.
- BIDLE or BRUN→EXIT on the exit flag.
- EXIT→NORMAL unconditionally.

Top module: `burst_supervisor`

## Requirements
- R1: While reset is asserted (active low, asynchronous), the block is in normal mode: `burst_active`=0, `pwm_enable`=1, `burst_gate`=0, `valley_reset`=0.
- R2: Burst is entered only when `fb_below_entry`=1 and `valley_set`=7 (the 3-bit valley count at its maximum) are both sampled high on BLANK_CYC+1 consecutive rising edges, where BLANK_CYC = (CLK_HZ/1_000_000)*BLANK_US. `burst_active` rises after that last edge.
- R3: If either entry condition is low on any edge before the window completes, the window restarts and a full BLANK_CYC+1 edges are needed again.
- R4: In burst, `fb_above_on` starts switching (`pwm_enable`=1) from the next cycle, and `fb_below_off` stops it (`pwm_enable`=0, `burst_gate`=0) from the next cycle.
- R5: While switching in burst, `burst_gate` repeats with period PER = CLK_HZ/BURST_HZ cycles. It is high for the first PER/2 cycles of each period, and each period starts with the gate high in the cycle after switching begins.
- R6: If `cs_burst_trip` is high while `burst_gate` is high, the gate goes low after the next edge and stays low until the next period starts.
- R7: When `fb_above_exit` is seen in burst, the next cycle shows `burst_active`=0, `pwm_enable`=1 and `valley_reset`=1. `valley_reset` lasts exactly one cycle.
- R8: When the exit flag and an on/off flag are high in the same cycle, exit wins.
- R9: Outside burst, `burst_gate` stays 0 and the on, off and trip flags have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fb_below_entry | input | 1 | Feedback below the burst entry level |
| fb_above_on | input | 1 | Feedback above the burst switching-on level |
| fb_below_off | input | 1 | Feedback below the burst switching-off level |
| fb_above_exit | input | 1 | Feedback above the burst exit level |
| valley_set | input | 3 | Current valley-count setting (1 to 7) |
| cs_burst_trip | input | 1 | Current sense above the burst peak limit |
| burst_active | output | 1 | Block is in the burst regime |
| burst_gate | output | 1 | Gate request from the burst pulse generator |
| pwm_enable | output | 1 | Switching is allowed (normal mode or burst on-phase) |
| valley_reset | output | 1 | One-cycle request to force the valley counter to 1 |

## Verification
The entry qualifier is tested with attempts that lose one condition at a random point inside the window. Some attempts drop the valley count and others drop the feedback flag. These runs show whether a broken window really restarts or only pauses, and they locate the exact edge on which burst begins.

The pulse generator is first run clean over several periods, which pins down the period and the duty cap. It is then run with current-sense trips at random cycles, which shows whether a cut pulse stays cut and whether the next period starts fresh.

Directed cases cover the remaining behaviour:
- exit raised together with an on or off flag, which exposes the priority order;
- the hysteresis band toggled on and off, which checks that the pulse phase restarts;
- random on, off and trip flags outside burst, which must leave every output untouched.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic [2:0] {
        ST_NORMAL,
        ST_BLANK,
        ST_BIDLE,
        ST_BRUN,
        ST_EXIT
    } burst_state_t;

    localparam logic [2:0] VALLEY_MAX = 3'd7;
endpackage

// File: rtl/burst_blank_timer.sv
module burst_blank_timer #(
    parameter int BLANK_CYC = 1200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic done
);
    localparam int BW = (BLANK_CYC > 1) ? $clog2(BLANK_CYC) : 1;
    localparam logic [BW-1:0] LAST = BW'(BLANK_CYC - 1);

    logic [BW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!count_en) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = count_en && (cnt == LAST);

    a_r3_restart_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> !done);
endmodule

// File: rtl/burst_pulse_gen.sv
module burst_pulse_gen #(
    parameter int PER_CYC = 961,
    parameter int ON_CYC  = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic trip,
    output logic gate
);
    localparam int PW = (PER_CYC > 2) ? $clog2(PER_CYC) : 1;
    localparam logic [PW-1:0] WRAP = PW'(PER_CYC - 1);
    localparam logic [PW-1:0] ON_L = PW'(ON_CYC);

    logic [PW-1:0] ph;
    logic          cut_q;
    logic          wrap;

    assign wrap = (ph == WRAP);
    assign gate = run && (ph < ON_L) && !cut_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph    <= '0;
            cut_q <= 1'b0;
        end else if (!run) begin
            ph    <= '0;
            cut_q <= 1'b0;
        end else begin
            ph <= wrap ? '0 : ph + 1'b1;
            if (wrap) begin
                cut_q <= 1'b0;
            end else if (trip && gate) begin
                cut_q <= 1'b1;
            end
        end
    end

    a_r6_trip_ends_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && trip) |=> !gate);
    a_r5_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$past(run)) |-> gate);
endmodule

// File: rtl/burst_supervisor.sv
module burst_supervisor
    import burst_pkg::*;
#(
    parameter int CLK_HZ   = 50000000,
    parameter int BURST_HZ = 52000,
    parameter int BLANK_US = 24000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fb_below_entry,
    input  logic       fb_above_on,
    input  logic       fb_below_off,
    input  logic       fb_above_exit,
    input  logic [2:0] valley_set,
    input  logic       cs_burst_trip,
    output logic       burst_active,
    output logic       burst_gate,
    output logic       pwm_enable,
    output logic       valley_reset
);
    localparam int PER_CYC   = CLK_HZ / BURST_HZ;
    localparam int ON_CYC    = PER_CYC / 2;
    localparam int BLANK_CYC = (CLK_HZ / 1000000) * BLANK_US;

    burst_state_t state, state_n;
    logic entry_ok;
    logic blank_done;
    logic run;

    assign entry_ok = fb_below_entry && (valley_set == VALLEY_MAX);
    assign run      = (state == ST_BRUN);

    burst_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (state == ST_BLANK && entry_ok),
        .done     (blank_done)
    );

    burst_pulse_gen #(.PER_CYC(PER_CYC), .ON_CYC(ON_CYC)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .trip  (cs_burst_trip),
        .gate  (burst_gate)
    );

    // next-state logic: exit is tested before the hysteresis band
    always_comb begin
        state_n = state;
        unique case (state)
            ST_NORMAL: if (entry_ok) state_n = ST_BLANK;
            ST_BLANK: begin
                if (!entry_ok)       state_n = ST_NORMAL;
                else if (blank_done) state_n = ST_BIDLE;
            end
            ST_BIDLE: begin
                if (fb_above_exit)    state_n = ST_EXIT;
                else if (fb_above_on) state_n = ST_BRUN;
            end
            ST_BRUN: begin
                if (fb_above_exit)     state_n = ST_EXIT;
                else if (fb_below_off) state_n = ST_BIDLE;
            end
            ST_EXIT:  state_n = ST_NORMAL;
            default:  state_n = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_NORMAL;
        else        state <= state_n;
    end

    always_comb begin
        burst_active = 1'b0;
        pwm_enable   = 1'b1;
        valley_reset = 1'b0;
        unique case (state)
            ST_NORMAL, ST_BLANK: ;
            ST_BIDLE: begin
                burst_active = 1'b1;
                pwm_enable   = 1'b0;
            end
            ST_BRUN:  burst_active = 1'b1;
            ST_EXIT:  valley_reset = 1'b1;
            default: ;
        endcase
    end

    a_r9_gate_only_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        burst_gate |-> burst_active);
    a_r4_idle_no_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && !pwm_enable) |-> !burst_gate);
    a_r7_single_reset: assert property (@(posedge clk) disable iff (!rst_n)
        valley_reset |=> !valley_reset);
    a_r7_reset_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valley_reset) |-> $past(burst_active));
    a_r2_entry_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_active) |-> $past(fb_below_entry && valley_set == VALLEY_MAX));
    a_r8_exit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && fb_above_exit) |=> (!burst_active && valley_reset));
endmodule

// File: tb/sim_burst_supervisor.sv
module sim_burst_supervisor;
    localparam int CLK_HZ    = 5200000;
    localparam int BURST_HZ  = 52000;
    localparam int BLANK_US  = 10;
    localparam int PER       = CLK_HZ / BURST_HZ;
    localparam int ON        = PER / 2;
    localparam int BLANK_CYC = (CLK_HZ / 1000000) * BLANK_US;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fb_below_entry = 1'b0, fb_above_on = 1'b0, fb_below_off = 1'b0;
    logic fb_above_exit = 1'b0, cs_burst_trip = 1'b0;
    logic [2:0] valley_set = 3'd1;
    logic burst_active, burst_gate, pwm_enable, valley_reset;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    burst_supervisor #(.CLK_HZ(CLK_HZ), .BURST_HZ(BURST_HZ), .BLANK_US(BLANK_US)) u0 (
        .clk(clk), .rst_n(rst_n),
        .fb_below_entry(fb_below_entry), .fb_above_on(fb_above_on),
        .fb_below_off(fb_below_off), .fb_above_exit(fb_above_exit),
        .valley_set(valley_set), .cs_burst_trip(cs_burst_trip),
        .burst_active(burst_active), .burst_gate(burst_gate),
        .pwm_enable(pwm_enable), .valley_reset(valley_reset)
    );

    function automatic logic exp_gate(int m, bit cut);
        return ((m % PER) < ON) && !cut;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R2 and R3: entry attempt broken once, then held for the full window
    task automatic enter_with_dropout(input bit drop_valley);
        int k;
        k = $urandom_range(BLANK_CYC, 1);
        valley_set = 3'd7;
        fb_below_entry = 1'b1;
        step(k);
        chk("R3 not active before drop", burst_active, 1'b0);
        if (drop_valley) valley_set = 3'($urandom_range(6, 1));
        else             fb_below_entry = 1'b0;
        step(1);
        chk("R3 not active at drop", burst_active, 1'b0);
        valley_set = 3'd7;
        fb_below_entry = 1'b1;
        step(BLANK_CYC);
        chk("R3 window restarted, still inactive", burst_active, 1'b0);
        step(1);
        chk("R2 active after full window", burst_active, 1'b1);
        fb_below_entry = 1'b0;
        valley_set = 3'd1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int m;
        bit cut;
        logic e;
        logic tr;
        void'($urandom(32'd2024));
        step(3);
        chk("R1 burst_active in reset", burst_active, 1'b0);
        chk("R1 pwm_enable in reset", pwm_enable, 1'b1);
        chk("R1 burst_gate in reset", burst_gate, 1'b0);
        chk("R1 valley_reset in reset", valley_reset, 1'b0);
        rst_n = 1'b1;
        step(1);

        // R9: random band and trip flags outside burst
        for (int i = 0; i < 20; i++) begin
            fb_above_on   = 1'($urandom_range(1, 0));
            fb_below_off  = 1'($urandom_range(1, 0));
            cs_burst_trip = 1'($urandom_range(1, 0));
            fb_above_exit = 1'($urandom_range(1, 0));
            valley_set    = 3'($urandom_range(7, 1));
            step(1);
            chk("R9 gate low outside burst", burst_gate, 1'b0);
            chk("R9 inactive outside burst", burst_active, 1'b0);
            chk("R9 pwm enabled outside burst", pwm_enable, 1'b1);
            chk("R9 no valley reset outside burst", valley_reset, 1'b0);
        end
        {fb_above_on, fb_below_off, cs_burst_trip, fb_above_exit} = 4'b0;
        valley_set = 3'd1;
        step(1);

        enter_with_dropout(1'b1);
        chk("R4 idle pwm off", pwm_enable, 1'b0);
        chk("R4 idle gate low", burst_gate, 1'b0);

        // R5/R6: run pulses, clean then with random trips
        fb_above_on = 1'b1;
        step(1);
        fb_above_on = 1'b0;
        chk("R4 on-level enables switching", pwm_enable, 1'b1);
        m = 0;
        cut = 1'b0;
        for (int i = 0; i < 4 * PER; i++) begin
            e = exp_gate(m, cut);
            chk(i < 2 * PER ? "R5 gate period/duty" : "R6 gate with trips", burst_gate, e);
            tr = (i >= 2 * PER) && ($urandom_range(15, 0) == 0);
            cs_burst_trip = tr;
            step(1);
            if ((m % PER) == PER - 1) cut = 1'b0;
            else if (tr && e)         cut = 1'b1;
            m++;
        end
        cs_burst_trip = 1'b0;

        // R4: off level pauses, on level restarts phase
        fb_below_off = 1'b1;
        step(1);
        fb_below_off = 1'b0;
        chk("R4 off-level pauses pwm", pwm_enable, 1'b0);
        chk("R4 off-level gate low", burst_gate, 1'b0);
        chk("R4 still in burst", burst_active, 1'b1);
        step(5);
        chk("R4 stays paused", burst_gate, 1'b0);
        fb_above_on = 1'b1;
        step(1);
        fb_above_on = 1'b0;
        chk("R5 new period starts high", burst_gate, 1'b1);

        // R8: exit with off flag while running
        fb_below_off = 1'b1;
        fb_above_exit = 1'b1;
        step(1);
        fb_below_off = 1'b0;
        fb_above_exit = 1'b0;
        chk("R8 exit beats off: valley_reset", valley_reset, 1'b1);
        chk("R7 exit clears burst_active", burst_active, 1'b0);
        chk("R7 exit enables pwm", pwm_enable, 1'b1);
        chk("R7 exit gate low", burst_gate, 1'b0);
        step(1);
        chk("R7 valley_reset one cycle", valley_reset, 1'b0);
        chk("R7 stays normal", burst_active, 1'b0);

        // R8: exit with on flag from idle
        enter_with_dropout(1'b0);
        fb_above_on = 1'b1;
        fb_above_exit = 1'b1;
        step(1);
        fb_above_on = 1'b0;
        fb_above_exit = 1'b0;
        chk("R8 exit beats on: valley_reset", valley_reset, 1'b1);
        chk("R8 exit beats on: inactive", burst_active, 1'b0);
        chk("R8 exit beats on: gate low", burst_gate, 1'b0);
        step(1);
        chk("R7 valley_reset one cycle (idle exit)", valley_reset, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule